// File: doc/BRIEF.md
# Serial Shortened BCH Double-Error-Correcting Encoder

This block turns a 16-bit data word, supplied one bit per clock with the most significant bit first, into a 26-bit systematic code word of a binary BCH code that corrects any two bit errors. The code is the length-31 code with 21 data bits and 10 check bits, shortened by removing five data positions. The generator polynomial is g(X) = X^10 + X^9 + X^8 + X^6 + X^5 + X^3 + 1. It is the product of the two degree-5 minimal polynomials X^5+X^2+1 and X^5+X^4+X^3+X^2+1.

A start pulse opens a word and clears the division register. The data bits then pass straight to the serial output and are folded into a feedback shift register that divides by g(X). After the sixteenth data bit, the feedback is switched off and the ten remainder bits are shifted out behind the data. A valid/ready pair on each side gives back-pressure at both ends. A one-cycle done pulse marks the handover of the final code bit.

Top module: `bch_serial_enc`

## Requirements
- R1: During reset and in the cycle after it, `dout_valid`, `done` and `din_ready` are low.
- R2: A `start` pulse in the idle state clears the remainder register and opens the data phase. `din_ready` is then high whenever the output slot is free.
- R3: The first 16 code bits on `dout` are the data bits, in the order they were accepted (data bit 15 first).
- R4: Code bits 17 to 26 are the remainder of d(X)·X^10 divided by g(X), with the full generator written as 11'h769. They are sent with the X^9 coefficient first. For data 16'h0001 the remainder is 10'h369, and for all-zero data it is 10'h000.
- R5: Every emitted 26-bit word, read as a polynomial with its first bit as the X^25 coefficient, is divisible by g(X).
- R6: `done` is high for exactly one cycle. That cycle is the one in which the 26th code bit is taken (`dout_valid` and `dout_ready` both high).
- R7: While `dout_valid` is high and `dout_ready` is low, the next cycle keeps `dout_valid` high and `dout` unchanged, and no code bit is lost or repeated.
- R8: `din_ready` is low once 16 data bits have been accepted, until the next word begins. `din_valid` is ignored during the check phase and while idle.
- R9: A `start` pulse during a word in progress, in either phase, has no effect on the emitted code word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new word when idle |
| din_valid | input | 1 | Serial data bit present |
| din | input | 1 | Serial data bit, most significant first |
| din_ready | output | 1 | Data bit will be taken this cycle |
| dout | output | 1 | Serial code bit |
| dout_valid | output | 1 | Code bit present on `dout` |
| dout_ready | input | 1 | Consumer takes the code bit |
| done | output | 1 | Final code bit of the word is taken |

## Verification
The bench builds the block with its default parameters: 16 data bits, 10 check bits and the 11'h769 generator. Under these defaults, the bench's long-division model can confirm each remainder bit and the divisibility of every whole word. Single-one data words at both ends of the word reach every feedback tap. All-ones data and mixed data, combined with stalls on the consumer side and gaps on the producer side, reach the hold and ordering behaviour. Stray start pulses and data offered outside the data phase exercise the ignore rules.

// File: rtl/bch_ser_pkg.sv
package bch_ser_pkg;
  // Sequencing phases of one code word
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DATA  = 2'd1,
    PH_CHECK = 2'd2,
    PH_DRAIN = 2'd3
  } bch_phase_t;

  // Low coefficients of g(X) = X^10+X^9+X^8+X^6+X^5+X^3+1 (X^10 implied)
  localparam logic [9:0] BCH_GEN_LOW = 10'h369;
endpackage

// File: rtl/bch_div_lfsr.sv
module bch_div_lfsr #(
  parameter int CHK_W = 10,
  parameter logic [CHK_W-1:0] GEN_LOW = bch_ser_pkg::BCH_GEN_LOW
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  input  logic feed_en,
  input  logic din,
  output logic msb
);
  logic [CHK_W-1:0] rem_q;
  logic [CHK_W-1:0] rem_n;
  logic             fb;

  // Feedback is zeroed during the check phase so the register only shifts
  assign fb  = feed_en & (din ^ rem_q[CHK_W-1]);
  assign msb = rem_q[CHK_W-1];

  generate
    for (genvar i = 0; i < CHK_W; i++) begin : g_tap
      if (i == 0) begin : g_low
        assign rem_n[i] = GEN_LOW[i] & fb;
      end else begin : g_mid
        assign rem_n[i] = rem_q[i-1] ^ (GEN_LOW[i] & fb);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) rem_q <= '0;
    else if (step)    rem_q <= rem_n;
  end
endmodule

// File: rtl/bch_seq_ctrl.sv
module bch_seq_ctrl
  import bch_ser_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic din_valid,
  input  logic slot_free,
  input  logic last_taken,
  output logic din_ready,
  output logic take_data,
  output logic take_check,
  output logic clear,
  output logic last_bit
);
  localparam int MAX_W = (DATA_W > CHK_W) ? DATA_W : CHK_W;
  localparam int CNT_W = $clog2(MAX_W);

  bch_phase_t       phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign clear      = (phase_q == PH_IDLE) && start;
  assign din_ready  = (phase_q == PH_DATA) && slot_free;
  assign take_data  = din_ready && din_valid;
  assign take_check = (phase_q == PH_CHECK) && slot_free;
  assign last_bit   = take_check && (cnt_q == CNT_W'(CHK_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_DATA;
          cnt_q   <= '0;
        end
        PH_DATA: if (take_data) begin
          if (cnt_q == CNT_W'(DATA_W-1)) begin
            phase_q <= PH_CHECK;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CHECK: if (take_check) begin
          if (last_bit) phase_q <= PH_DRAIN;
          else          cnt_q   <= cnt_q + 1'b1;
        end
        default: if (last_taken) phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bch_out_stage.sv
module bch_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic bit_in,
  input  logic last_in,
  input  logic dout_ready,
  output logic dout,
  output logic dout_valid,
  output logic dout_last,
  output logic slot_free,
  output logic fire
);
  assign fire      = dout_valid && dout_ready;
  assign slot_free = !dout_valid || dout_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= 1'b0;
      dout_valid <= 1'b0;
      dout_last  <= 1'b0;
    end else if (load) begin
      dout       <= bit_in;
      dout_valid <= 1'b1;
      dout_last  <= last_in;
    end else if (fire) begin
      dout_valid <= 1'b0;
      dout_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/bch_serial_enc.sv
module bch_serial_enc #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 10,
  parameter logic [CHK_W-1:0] GEN_LOW = bch_ser_pkg::BCH_GEN_LOW
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic din_valid,
  input  logic din,
  output logic din_ready,
  output logic dout,
  output logic dout_valid,
  input  logic dout_ready,
  output logic done
);
  logic take_data, take_check, clear, last_bit;
  logic slot_free, fire, dout_last, rem_msb;

  bch_seq_ctrl #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .din_valid(din_valid),
    .slot_free(slot_free), .last_taken(done), .din_ready(din_ready),
    .take_data(take_data), .take_check(take_check), .clear(clear),
    .last_bit(last_bit)
  );

  bch_div_lfsr #(.CHK_W(CHK_W), .GEN_LOW(GEN_LOW)) u_div (
    .clk(clk), .rst(rst), .clear(clear), .step(take_data || take_check),
    .feed_en(take_data), .din(din), .msb(rem_msb)
  );

  bch_out_stage u_out (
    .clk(clk), .rst(rst), .load(take_data || take_check),
    .bit_in(take_data ? din : rem_msb), .last_in(last_bit),
    .dout_ready(dout_ready), .dout(dout), .dout_valid(dout_valid),
    .dout_last(dout_last), .slot_free(slot_free), .fire(fire)
  );

  assign done = fire && dout_last;
endmodule

// File: rtl/bch_serial_enc_chk.sv
module bch_serial_enc_chk #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 10
) (
  input logic clk,
  input logic rst,
  input logic din_valid,
  input logic din_ready,
  input logic dout,
  input logic dout_valid,
  input logic dout_ready,
  input logic done
);
  localparam int CW    = DATA_W + CHK_W;
  localparam int OCW_W = $clog2(CW + 1);
  localparam int ICW_W = $clog2(DATA_W + 1);

  logic [OCW_W-1:0] out_cnt;
  logic [ICW_W-1:0] in_cnt;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      out_cnt <= '0;
      in_cnt  <= '0;
    end else begin
      if (dout_valid && dout_ready) out_cnt <= out_cnt + 1'b1;
      if (din_valid && din_ready)   in_cnt  <= in_cnt + 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!dout_valid && !done && !din_ready));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout)));

  a_r6_done_on_take: assert property (@(posedge clk) disable iff (rst)
    done |-> (dout_valid && dout_ready));

  a_r6_done_last_bit: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_cnt == OCW_W'(CW-1)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_ready_window: assert property (@(posedge clk) disable iff (rst)
    din_ready |-> (in_cnt < ICW_W'(DATA_W)));
endmodule

bind bch_serial_enc bch_serial_enc_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
  .clk(clk), .rst(rst), .din_valid(din_valid), .din_ready(din_ready),
  .dout(dout), .dout_valid(dout_valid), .dout_ready(dout_ready), .done(done)
);

// File: tb/test_bch_serial_enc.sv
module test_bch_serial_enc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, din_valid = 1'b0, din = 1'b0, dout_ready = 1'b1;
  logic din_ready, dout, dout_valid, done;

  always #5 clk = ~clk;

  bch_serial_enc i_bch_serial_enc (
    .clk(clk), .rst(rst), .start(start), .din_valid(din_valid), .din(din),
    .din_ready(din_ready), .dout(dout), .dout_valid(dout_valid),
    .dout_ready(dout_ready), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int stall_mode = 0;
  int cyc = 0;
  int words_done = 0;
  bit exp_q[$];
  int pos = 0, in_acc = 0;
  logic [25:0] got_word = '0;
  bit prev_stall = 0;
  logic prev_dout = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] mod_g(input logic [25:0] w);
    logic [25:0] m = w;
    for (int i = 25; i >= 10; i--)
      if (m[i]) m = m ^ (26'h769 << (i - 10));
    return m;
  endfunction

  // consumer-side ready pattern
  always @(posedge clk) begin
    #2;
    cyc++;
    case (stall_mode)
      0: dout_ready = 1'b1;
      1: dout_ready = (cyc % 3) != 0;
      default: dout_ready = (cyc % 5) > 2;
    endcase
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(dout_valid && dout == prev_dout, "R7 hold", {dout_valid, dout}, {1'b1, prev_dout});
      prev_stall = dout_valid && !dout_ready;
      prev_dout  = dout;
      if (din_ready && in_acc >= 16)
        check(1'b0, "R8 ready after data", 1, 0);
      if (din_valid && din_ready) in_acc++;
      if (dout_valid && dout_ready) begin
        bit e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected bit", dout, 0);
        end else begin
          e = exp_q.pop_front();
          check(dout == e, pos < 16 ? "R3 data bit" : "R4 check bit", dout, e);
        end
        got_word = {got_word[24:0], dout};
        pos++;
        check(done == (pos == 26), "R6 done timing", done, pos == 26);
        if (pos == 26) begin
          check(mod_g(got_word) == '0, "R5 divisible", mod_g(got_word), 0);
          pos = 0;
          in_acc = 0;
          words_done++;
        end
      end else if (done) begin
        check(1'b0, "R6 done without take", 1, 0);
      end
    end
  end

  task automatic send_word(input logic [15:0] d, input bit gaps, input bit stray_start,
                           input bit check_open);
    logic [25:0] cw;
    int target;
    cw = {d, 10'b0};
    cw = cw | mod_g(cw);
    for (int b = 25; b >= 0; b--) exp_q.push_back(cw[b]);
    target = words_done + 1;
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    if (check_open) begin
      @(negedge clk);
      check(din_ready == 1'b1, "R2 data phase open", din_ready, 1);
      @(posedge clk); #2;
    end
    for (int i = 15; i >= 0; i--) begin
      din_valid = 1'b1;
      din = d[i];
      if (stray_start && i == 8) start = 1'b1;   // R9 during data phase
      @(negedge clk);
      while (!din_ready) @(negedge clk);
      @(posedge clk); #2;
      start = 1'b0;
      if (gaps && (i % 2 == 0)) begin
        din_valid = 1'b0;
        @(posedge clk); #2;
      end
    end
    // R8: offer garbage during the check phase
    din_valid = 1'b1;
    din = 1'b1;
    if (stray_start) begin   // R9 during check phase
      start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    while (words_done < target) @(negedge clk);
    @(posedge clk); #2 din_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(!dout_valid && !done && !din_ready, "R1 reset state",
          {dout_valid, done, din_ready}, 0);
    // R8: data offered while idle is ignored
    din_valid = 1'b1;
    din = 1'b1;
    repeat (3) @(negedge clk);
    check(!dout_valid, "R8 idle ignores data", dout_valid, 0);
    din_valid = 1'b0;

    stall_mode = 0;
    send_word(16'h0001, 0, 0, 1);  // R4 remainder 10'h369
    send_word(16'h0000, 0, 0, 0);  // R4 remainder zero
    send_word(16'h8000, 0, 0, 0);
    send_word(16'hFFFF, 1, 0, 0);
    stall_mode = 1;
    send_word(16'hA5C3, 0, 0, 0);  // R7
    send_word(16'h1234, 1, 1, 0);  // R9
    stall_mode = 2;
    send_word(16'h0F0F, 0, 1, 0);
    for (int k = 0; k < 16; k += 5) send_word(16'h1 << k, k % 2 == 1, 0, 0);
    stall_mode = 0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !dout_valid, "R9 no extra word", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule